// File: doc/BRIEF.md
# Idle Timer and SMI Event Controller

This power-management block watches eight activity inputs of a PC-style system. Any source whose reload enable is set restarts a primary idle timer and leaves a sticky mark in a reload-cause register. The idle timer measures a programmable timeout, from one second up to thirty-two minutes. A second, 8-bit general-purpose timer counts down a loaded value in units of a selectable time base. All time bases are made from a tick-enable input and three parameters: ticks per fast period, ticks per second and seconds per minute. A test can therefore shrink every period without touching the logic.

Eight event causes can raise a system-management interrupt, each behind its own enable: idle timeout, general-purpose timeout, primary activity, primary interrupt, a level change on an external pin, a DMA request, a peripheral-timer timeout and a software strobe. Each cause that fires while enabled sets a sticky status bit. Software clears a status bit by writing 1 to it. The active-low SMI output stays low while any status bit that is set also has its enable set.

A timer that has expired keeps that state until something reloads it. If a reload and a timeout fall in the same clock, the reload wins and no timeout event is raised.

Top module: `pm_smi_ctrl`

## Requirements
- R1: After reset every register reads 0x00 and smi_n_o is 1.
- R2: The register map is at reg_addr_i: 0 = reload enables, 1 = reload causes (write-1-to-clear), 2 = idle timeout code in bits 2:0, 3 = general timer base in bits 1:0, 4 = general timer load value, 5 = SMI enables, 6 = SMI status (write-1-to-clear), 7 reads 0x00. Unused bits read 0. Reads are combinational from the stored state.
- R3: act_i bit positions are: 7 keyboard, 6 serial, 5 parallel, 4 video, 3 disk/floppy, 2 I/O range 100h-3FFh, 1 external input, 0 DMA/bus-master request. A pulse on a bit whose reload enable is set reloads the idle timer and sets the same bit of the reload-cause register at that clock edge. A pulse on a bit whose enable is clear does neither.
- R4: Reload-cause bits are sticky. A write with bit i = 1 to address 1 clears bit i, unless the source fires again in the same cycle.
- R5: Idle code 1..7 gives a timeout of 1 s, 8 s, 32 s, 1 min, 8 min, 16 min or 32 min, measured in TICKS_SEC ticks per second and SECS_MIN seconds per minute. The timeout event comes at the edge where the tick count since the reload reaches that length. Code 0 never times out.
- R6: An expired timer neither counts nor raises another event until it is reloaded. The idle timer is reloaded by an enabled activity pulse or any write to address 2. The general timer is reloaded by any write to address 3 or 4.
- R7: A reload and a timeout on the same edge resolve to the reload, and no timeout event is raised.
- R8: The general timer base code gives 00 disabled, 01 TICKS_FAST ticks, 10 one second, 11 one minute per period. A load value N expires after N periods, and N = 0 expires after 256 periods.
- R9: Both timers advance only on cycles where tick_i is 1.
- R10: SMI status bits are: 7 idle timeout, 6 general timeout, 5 primary activity (any enabled reload), 4 irq_i, 3 ext_pin_i level change, 2 act_i[0], 1 periph_to_i, 0 sw_smi_i. A cause sets its status bit at its edge only if the same SMI enable bit is set.
- R11: Status bits are sticky and cleared by writing 1 to address 6. A cause that fires in the same cycle as its clear leaves the bit set.
- R12: smi_n_o is registered. It is 0 exactly when (status AND enables) is nonzero, and it follows the status and enable registers on the same edge.
- R13: A rising or a falling level change on ext_pin_i counts as a pin toggle event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time-base tick enable |
| act_i | input | 8 | Activity pulses, one per source |
| irq_i | input | 1 | Primary interrupt pulse |
| ext_pin_i | input | 1 | External pin level |
| periph_to_i | input | 1 | Peripheral timer timeout pulse |
| sw_smi_i | input | 1 | Software SMI strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| smi_n_o | output | 1 | Active-low SMI request |

## Verification
A pulse, a write-1-to-clear or a cause is applied before one clock edge. Its effect on status, causes and smi_n_o is due at that same edge. The bench samples at the following falling edge. After a reload on edge E0, a timeout is due exactly at edge E0 plus the period length in ticks. The bench checks one edge before that point for no event and at that point for the event. Tick gaps are added to the expected edge count.

// File: rtl/pm_pkg.sv
package pm_pkg;

    localparam int DW = 8;

    // register addresses
    localparam logic [2:0] A_ACT_EN    = 3'd0;
    localparam logic [2:0] A_ACT_CAUSE = 3'd1;
    localparam logic [2:0] A_IDLE_CFG  = 3'd2;
    localparam logic [2:0] A_GP_CFG    = 3'd3;
    localparam logic [2:0] A_GP_LOAD   = 3'd4;
    localparam logic [2:0] A_SMI_EN    = 3'd5;
    localparam logic [2:0] A_SMI_STAT  = 3'd6;

    // SMI cause bit positions
    localparam int C_SW     = 0;
    localparam int C_PERIPH = 1;
    localparam int C_DMA    = 2;
    localparam int C_PIN    = 3;
    localparam int C_IRQ    = 4;
    localparam int C_ACT    = 5;
    localparam int C_GP     = 6;
    localparam int C_IDLE   = 7;

    // activity bit that doubles as the DMA request cause
    localparam int S_DMA = 0;

    function automatic int unsigned idle_ticks(input logic [2:0] code,
                                               input int unsigned tps,
                                               input int unsigned spm);
        case (code)
            3'd1:    return tps;
            3'd2:    return 8 * tps;
            3'd3:    return 32 * tps;
            3'd4:    return spm * tps;
            3'd5:    return 8 * spm * tps;
            3'd6:    return 16 * spm * tps;
            3'd7:    return 32 * spm * tps;
            default: return 0;
        endcase
    endfunction

    function automatic int unsigned base_ticks(input logic [1:0] base,
                                               input int unsigned tf,
                                               input int unsigned tps,
                                               input int unsigned spm);
        case (base)
            2'd1:    return tf;
            2'd2:    return tps;
            2'd3:    return spm * tps;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/pm_sticky.sv
module pm_sticky #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o,
    output logic [W-1:0] nxt_o
);
    typedef struct packed {
        logic [W-1:0] bits;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // set has priority over clear so no event is lost
        st_d.bits = (st_q.bits & ~clr_i) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o   = st_q.bits;
    assign nxt_o = st_d.bits;
endmodule

// File: rtl/pm_idle_timer.sv
module pm_idle_timer #(
    parameter int unsigned TICKS_SEC = 32768,
    parameter int unsigned SECS_MIN  = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic [2:0] code_i,
    input  logic       reload_i,
    output logic       expired_o,
    output logic       timeout_o
);
    localparam int unsigned MAX_T = 32 * SECS_MIN * TICKS_SEC;
    localparam int          CW    = $clog2(MAX_T + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          exp;
    } st_t;

    st_t           st_d, st_q;
    logic [CW-1:0] limit;

    always_comb begin
        st_d      = st_q;
        timeout_o = 1'b0;
        limit     = CW'(pm_pkg::idle_ticks(code_i, TICKS_SEC, SECS_MIN));
        if (reload_i) begin
            st_d.cnt = '0;
            st_d.exp = 1'b0;
        end else if (!st_q.exp && (code_i != 3'd0) && tick_i) begin
            if (st_q.cnt == limit - CW'(1)) begin
                st_d.exp  = 1'b1;
                timeout_o = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expired_o = st_q.exp;
endmodule

// File: rtl/pm_gp_timer.sv
module pm_gp_timer #(
    parameter int unsigned TICKS_FAST = 1,
    parameter int unsigned TICKS_SEC  = 32768,
    parameter int unsigned SECS_MIN   = 60,
    parameter int          DW         = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic [1:0]    base_i,
    input  logic [DW-1:0] load_i,
    input  logic          reload_i,
    output logic          expired_o,
    output logic          timeout_o
);
    localparam int unsigned PMAX = (TICKS_SEC * SECS_MIN > TICKS_FAST) ?
                                   TICKS_SEC * SECS_MIN : TICKS_FAST;
    localparam int          PW   = $clog2(PMAX + 1);

    typedef struct packed {
        logic [PW-1:0] pre;
        logic [DW-1:0] cnt;
        logic          exp;
    } st_t;

    st_t           st_d, st_q;
    logic [PW-1:0] period;

    always_comb begin
        st_d      = st_q;
        timeout_o = 1'b0;
        period    = PW'(pm_pkg::base_ticks(base_i, TICKS_FAST, TICKS_SEC, SECS_MIN));
        if (reload_i) begin
            st_d.pre = '0;
            st_d.cnt = load_i;
            st_d.exp = 1'b0;
        end else if (!st_q.exp && (base_i != 2'd0) && tick_i) begin
            if (st_q.pre == period - PW'(1)) begin
                st_d.pre = '0;
                st_d.cnt = st_q.cnt - DW'(1);
                if (st_q.cnt == DW'(1)) begin
                    st_d.exp  = 1'b1;
                    timeout_o = 1'b1;
                end
            end else begin
                st_d.pre = st_q.pre + PW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expired_o = st_q.exp;
endmodule

// File: rtl/pm_smi_ctrl.sv
module pm_smi_ctrl #(
    parameter int unsigned TICKS_FAST = 1,
    parameter int unsigned TICKS_SEC  = 32768,
    parameter int unsigned SECS_MIN   = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_i,
    input  logic [7:0] act_i,
    input  logic       irq_i,
    input  logic       ext_pin_i,
    input  logic       periph_to_i,
    input  logic       sw_smi_i,
    input  logic       reg_we_i,
    input  logic [2:0] reg_addr_i,
    input  logic [7:0] reg_wdata_i,
    output logic [7:0] reg_rdata_o,
    output logic       smi_n_o
);
    import pm_pkg::*;

    typedef struct packed {
        logic [DW-1:0] act_en;
        logic [2:0]    idle_code;
        logic [1:0]    gp_base;
        logic [DW-1:0] gp_load;
        logic [DW-1:0] smi_en;
        logic          pin;
        logic          smi_n;
    } regs_t;

    regs_t r_d, r_q;

    logic          wr_act_en, wr_cause, wr_idle, wr_gp_cfg, wr_gp_load, wr_smi_en, wr_stat;
    logic [DW-1:0] act_en_q, smi_en_q;
    logic [DW-1:0] act_hit;
    logic [DW-1:0] act_cause_q, act_cause_clr, act_cause_d;
    logic [DW-1:0] smi_cause, smi_set, smi_stat_q, smi_stat_clr, smi_stat_d;
    logic          idle_reload, idle_to, idle_exp;
    logic          gp_reload, gp_to, gp_exp;
    logic          pin_toggle;

    assign act_en_q = r_q.act_en;
    assign smi_en_q = r_q.smi_en;

    // write decode
    always_comb begin
        wr_act_en  = reg_we_i && (reg_addr_i == A_ACT_EN);
        wr_cause   = reg_we_i && (reg_addr_i == A_ACT_CAUSE);
        wr_idle    = reg_we_i && (reg_addr_i == A_IDLE_CFG);
        wr_gp_cfg  = reg_we_i && (reg_addr_i == A_GP_CFG);
        wr_gp_load = reg_we_i && (reg_addr_i == A_GP_LOAD);
        wr_smi_en  = reg_we_i && (reg_addr_i == A_SMI_EN);
        wr_stat    = reg_we_i && (reg_addr_i == A_SMI_STAT);
    end

    // event gathering
    always_comb begin
        act_hit       = act_i & act_en_q;
        idle_reload   = (|act_hit) || wr_idle;
        gp_reload     = wr_gp_cfg || wr_gp_load;
        pin_toggle    = ext_pin_i ^ r_q.pin;
        act_cause_clr = wr_cause ? reg_wdata_i : '0;
        smi_stat_clr  = wr_stat ? reg_wdata_i : '0;
        smi_cause          = '0;
        smi_cause[C_IDLE]   = idle_to;
        smi_cause[C_GP]     = gp_to;
        smi_cause[C_ACT]    = |act_hit;
        smi_cause[C_IRQ]    = irq_i;
        smi_cause[C_PIN]    = pin_toggle;
        smi_cause[C_DMA]    = act_i[S_DMA];
        smi_cause[C_PERIPH] = periph_to_i;
        smi_cause[C_SW]     = sw_smi_i;
        smi_set = smi_cause & smi_en_q;
    end

    // register next state
    always_comb begin
        r_d = r_q;
        if (wr_act_en)  r_d.act_en    = reg_wdata_i;
        if (wr_idle)    r_d.idle_code = reg_wdata_i[2:0];
        if (wr_gp_cfg)  r_d.gp_base   = reg_wdata_i[1:0];
        if (wr_gp_load) r_d.gp_load   = reg_wdata_i;
        if (wr_smi_en)  r_d.smi_en    = reg_wdata_i;
        r_d.pin   = ext_pin_i;
        r_d.smi_n = ~|(smi_stat_d & r_d.smi_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.smi_n <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    pm_idle_timer #(
        .TICKS_SEC (TICKS_SEC),
        .SECS_MIN  (SECS_MIN)
    ) i_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .code_i    (r_q.idle_code),
        .reload_i  (idle_reload),
        .expired_o (idle_exp),
        .timeout_o (idle_to)
    );

    pm_gp_timer #(
        .TICKS_FAST (TICKS_FAST),
        .TICKS_SEC  (TICKS_SEC),
        .SECS_MIN   (SECS_MIN),
        .DW         (DW)
    ) i_gp (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_i    (tick_i),
        .base_i    (r_q.gp_base),
        .load_i    (r_d.gp_load),
        .reload_i  (gp_reload),
        .expired_o (gp_exp),
        .timeout_o (gp_to)
    );

    pm_sticky #(.W(DW)) i_act_cause (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (act_hit),
        .clr_i (act_cause_clr),
        .q_o   (act_cause_q),
        .nxt_o (act_cause_d)
    );

    pm_sticky #(.W(DW)) i_smi_stat (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (smi_set),
        .clr_i (smi_stat_clr),
        .q_o   (smi_stat_q),
        .nxt_o (smi_stat_d)
    );

    // read mux
    always_comb begin
        case (reg_addr_i)
            A_ACT_EN:    reg_rdata_o = r_q.act_en;
            A_ACT_CAUSE: reg_rdata_o = act_cause_q;
            A_IDLE_CFG:  reg_rdata_o = {5'd0, r_q.idle_code};
            A_GP_CFG:    reg_rdata_o = {6'd0, r_q.gp_base};
            A_GP_LOAD:   reg_rdata_o = r_q.gp_load;
            A_SMI_EN:    reg_rdata_o = r_q.smi_en;
            A_SMI_STAT:  reg_rdata_o = smi_stat_q;
            default:     reg_rdata_o = '0;
        endcase
    end

    assign smi_n_o = r_q.smi_n;
endmodule

// File: rtl/pm_smi_ctrl_chk.sv
module pm_smi_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       smi_n,
    input logic [7:0] stat,
    input logic [7:0] stat_clr,
    input logic [7:0] smi_en,
    input logic [7:0] cause,
    input logic [7:0] cause_clr,
    input logic [7:0] act_en,
    input logic       idle_exp,
    input logic       idle_reload,
    input logic       gp_exp,
    input logic       gp_reload
);
    a_r11_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((($past(stat) & ~$past(stat_clr)) & ~stat)) == 8'h00));

    a_r12_smi_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(smi_n) |-> ((stat & smi_en) != 8'h00));

    a_r12_smi_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(smi_n) |-> ((stat & smi_en) == 8'h00));

    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_exp && !idle_reload) |=> idle_exp);

    a_r6_gp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (gp_exp && !gp_reload) |=> gp_exp);

    a_r7_reload_no_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_reload && !stat[7]) |=> !stat[7]);

    a_r3_cause_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cause & ~$past(cause) & ~$past(act_en)) == 8'h00));

    a_r4_cause_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((($past(cause) & ~$past(cause_clr)) & ~cause)) == 8'h00));
endmodule

bind pm_smi_ctrl pm_smi_ctrl_chk i_pm_smi_ctrl_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .smi_n       (smi_n_o),
    .stat        (smi_stat_q),
    .stat_clr    (smi_stat_clr),
    .smi_en      (smi_en_q),
    .cause       (act_cause_q),
    .cause_clr   (act_cause_clr),
    .act_en      (act_en_q),
    .idle_exp    (idle_exp),
    .idle_reload (idle_reload),
    .gp_exp      (gp_exp),
    .gp_reload   (gp_reload)
);

// File: tb/test_pm_smi_ctrl.sv
`timescale 1ns/1ps
module test_pm_smi_ctrl;
    localparam int unsigned TF  = 2;
    localparam int unsigned TPS = 8;
    localparam int unsigned SPM = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b1;
    logic [7:0] act_i = '0;
    logic       irq_i = 1'b0;
    logic       ext_pin_i = 1'b0;
    logic       periph_to_i = 1'b0;
    logic       sw_smi_i = 1'b0;
    logic       reg_we_i = 1'b0;
    logic [2:0] reg_addr_i = '0;
    logic [7:0] reg_wdata_i = '0;
    logic [7:0] reg_rdata_o;
    logic       smi_n_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pm_smi_ctrl #(.TICKS_FAST(TF), .TICKS_SEC(TPS), .SECS_MIN(SPM)) i_pm_smi_ctrl (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .act_i(act_i), .irq_i(irq_i),
        .ext_pin_i(ext_pin_i), .periph_to_i(periph_to_i), .sw_smi_i(sw_smi_i),
        .reg_we_i(reg_we_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .smi_n_o(smi_n_o)
    );

    function automatic int exp_idle(input int code);
        int secs [8] = '{0, 1, 8, 32, 60, 480, 960, 1920};
        if (code >= 4) return (secs[code] / 60) * SPM * TPS;
        return secs[code] * TPS;
    endfunction

    function automatic int exp_gp(input int base, input int n);
        int per;
        per = (base == 1) ? TF : (base == 2) ? TPS : SPM * TPS;
        return ((n == 0) ? 256 : n) * per;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_we_i = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        reg_addr_i = a;
        #1;
        v = reg_rdata_o;
    endtask

    task automatic chk_reg(input string req, input logic [2:0] a, input logic [7:0] e);
        logic [7:0] v;
        rd(a, v);
        check(req, {24'd0, v}, {24'd0, e});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] m_act_en, m_smi_en, m_cause, m_stat;
        int l;
        void'($urandom(32'd20240611));
        cyc(3);
        rst_n = 1'b1;
        cyc(1);

        // R1 reset state
        for (int a = 0; a < 8; a++) chk_reg("R1 reset reg", 3'(a), 8'h00);
        check("R1 smi_n reset", {31'd0, smi_n_o}, 32'd1);

        // R2 readback and field widths
        wr(3'd0, 8'hA5); chk_reg("R2 act_en", 3'd0, 8'hA5);
        wr(3'd2, 8'hFF); chk_reg("R2 idle cfg", 3'd2, 8'h07);
        wr(3'd2, 8'h00);
        wr(3'd3, 8'hFF); chk_reg("R2 gp cfg", 3'd3, 8'h03);
        wr(3'd3, 8'h00);
        wr(3'd4, 8'h5A); chk_reg("R2 gp load", 3'd4, 8'h5A);
        wr(3'd7, 8'hFF); chk_reg("R2 addr7", 3'd7, 8'h00);
        wr(3'd0, 8'h00);

        // R10 / R12 / R13 individual causes
        wr(3'd5, 8'hFF);
        sw_smi_i = 1; cyc(1); sw_smi_i = 0;
        chk_reg("R10 sw", 3'd6, 8'h01);
        check("R12 smi low", {31'd0, smi_n_o}, 32'd0);
        wr(3'd6, 8'h01);
        chk_reg("R11 clear", 3'd6, 8'h00);
        check("R12 smi high", {31'd0, smi_n_o}, 32'd1);
        irq_i = 1; cyc(1); irq_i = 0;
        chk_reg("R10 irq", 3'd6, 8'h10); wr(3'd6, 8'hFF);
        periph_to_i = 1; cyc(1); periph_to_i = 0;
        chk_reg("R10 periph", 3'd6, 8'h02); wr(3'd6, 8'hFF);
        act_i = 8'h01; cyc(1); act_i = 0;
        chk_reg("R10 dma", 3'd6, 8'h04);
        chk_reg("R3 disabled source no cause", 3'd1, 8'h00);
        wr(3'd6, 8'hFF);
        ext_pin_i = 1; cyc(1);
        chk_reg("R13 rising", 3'd6, 8'h08); wr(3'd6, 8'hFF);
        ext_pin_i = 0; cyc(1);
        chk_reg("R13 falling", 3'd6, 8'h08); wr(3'd6, 8'hFF);
        cyc(2);
        chk_reg("R13 steady", 3'd6, 8'h00);
        wr(3'd5, 8'hFE);
        sw_smi_i = 1; cyc(1); sw_smi_i = 0;
        chk_reg("R10 disabled cause", 3'd6, 8'h00);
        check("R10 smi stays high", {31'd0, smi_n_o}, 32'd1);
        wr(3'd5, 8'hFF);
        sw_smi_i = 1; cyc(1); sw_smi_i = 0;
        wr(3'd5, 8'h00);
        check("R12 masked", {31'd0, smi_n_o}, 32'd1);
        chk_reg("R12 status kept", 3'd6, 8'h01);
        wr(3'd5, 8'hFF);
        check("R12 unmasked", {31'd0, smi_n_o}, 32'd0);
        sw_smi_i = 1; wr(3'd6, 8'h01); sw_smi_i = 0;
        chk_reg("R11 set beats clear", 3'd6, 8'h01);
        wr(3'd6, 8'hFF);

        // R5 idle timeout, code 1
        l = exp_idle(1);
        wr(3'd0, 8'h80);
        wr(3'd2, 8'h01);
        cyc(l - 1); chk_reg("R5 before timeout", 3'd6, 8'h00);
        cyc(1);     chk_reg("R5 at timeout", 3'd6, 8'h80);
        check("R12 smi on idle", {31'd0, smi_n_o}, 32'd0);
        // R6 expired holds
        wr(3'd6, 8'hFF);
        cyc(3 * l); chk_reg("R6 no recount", 3'd6, 8'h00);
        act_i = 8'h80; cyc(1); act_i = 0;
        chk_reg("R3 cause latched", 3'd1, 8'h80);
        chk_reg("R10 primary activity", 3'd6, 8'h20);
        wr(3'd6, 8'hFF);
        cyc(l - 2); chk_reg("R6 reload by activity early", 3'd6, 8'h00);
        cyc(1);     chk_reg("R6 reload by activity", 3'd6, 8'h80);
        wr(3'd1, 8'h80); chk_reg("R4 cause clear", 3'd1, 8'h00);
        // R3 disabled source ignored
        wr(3'd6, 8'hFF);
        wr(3'd2, 8'h01);
        cyc(l - 1);
        act_i = 8'h40; cyc(1); act_i = 0;
        chk_reg("R3 disabled no reload", 3'd6, 8'h80);
        chk_reg("R3 disabled no cause", 3'd1, 8'h00);
        // R7 reload and timeout same edge
        wr(3'd6, 8'hFF);
        wr(3'd2, 8'h01);
        cyc(l - 1);
        act_i = 8'h80; cyc(1); act_i = 0;
        chk_reg("R7 reload wins", 3'd6, 8'h20);
        cyc(l - 1); chk_reg("R7 restarted early", 3'd6, 8'h20);
        cyc(1);     chk_reg("R7 restarted expiry", 3'd6, 8'hA0);
        // R9 tick gating
        wr(3'd6, 8'hFF);
        wr(3'd2, 8'h01);
        tick_i = 0; cyc(20); tick_i = 1;
        cyc(l - 1); chk_reg("R9 no count without tick", 3'd6, 8'h00);
        cyc(1);     chk_reg("R9 delayed expiry", 3'd6, 8'h80);
        // R5 minute code
        wr(3'd6, 8'hFF);
        l = exp_idle(4);
        wr(3'd2, 8'h04);
        cyc(l - 1); chk_reg("R5 code4 early", 3'd6, 8'h00);
        cyc(1);     chk_reg("R5 code4 expiry", 3'd6, 8'h80);
        wr(3'd2, 8'h00); wr(3'd6, 8'hFF);
        cyc(300);   chk_reg("R5 code0 disabled", 3'd6, 8'h00);

        // R8 general timer
        wr(3'd3, 8'h01);
        wr(3'd4, 8'h03);
        l = exp_gp(1, 3);
        cyc(l - 1); chk_reg("R8 fast early", 3'd6, 8'h00);
        cyc(1);     chk_reg("R8 fast expiry", 3'd6, 8'h40);
        wr(3'd6, 8'hFF);
        cyc(50);    chk_reg("R6 gp holds", 3'd6, 8'h00);
        wr(3'd3, 8'h02);
        l = exp_gp(2, 3);
        cyc(l - 1); chk_reg("R8 sec early", 3'd6, 8'h00);
        cyc(1);     chk_reg("R8 sec expiry", 3'd6, 8'h40);
        wr(3'd6, 8'hFF);
        wr(3'd3, 8'h03);
        wr(3'd4, 8'h02);
        l = exp_gp(3, 2);
        cyc(l - 1); chk_reg("R8 min early", 3'd6, 8'h00);
        cyc(1);     chk_reg("R8 min expiry", 3'd6, 8'h40);
        wr(3'd6, 8'hFF);
        wr(3'd3, 8'h01);
        wr(3'd4, 8'h00);
        l = exp_gp(1, 0);
        cyc(l - 1); chk_reg("R8 zero load early", 3'd6, 8'h00);
        cyc(1);     chk_reg("R8 zero load 256", 3'd6, 8'h40);
        wr(3'd3, 8'h00); wr(3'd6, 8'hFF);
        cyc(600);   chk_reg("R8 base0 disabled", 3'd6, 8'h00);

        // random phase: R3 R4 R10 R11 R12
        wr(3'd1, 8'hFF);
        m_act_en = 8'h00; m_smi_en = 8'hFF; m_cause = 8'h00; m_stat = 8'h00;
        wr(3'd0, m_act_en);
        for (int it = 0; it < 400; it++) begin
            logic [31:0] r;
            logic [7:0]  a, wm, sc, cs;
            logic [1:0]  ws;
            r = $urandom;
            if (r[7:6] == 2'd0) begin
                m_act_en = 8'($urandom);
                m_smi_en = 8'($urandom);
                wr(3'd0, m_act_en);
                wr(3'd5, m_smi_en);
            end
            a  = 8'($urandom);
            ws = r[5:4];
            wm = r[15:8];
            cs = a & m_act_en;
            sc = {2'b00, |cs, r[0], r[3], a[0], r[1], r[2]};
            m_cause = (m_cause & ~((ws == 2'd1) ? wm : 8'h00)) | cs;
            m_stat  = (m_stat  & ~((ws == 2'd2) ? wm : 8'h00)) | (sc & m_smi_en);
            act_i = a; irq_i = r[0]; periph_to_i = r[1]; sw_smi_i = r[2];
            ext_pin_i = ext_pin_i ^ r[3];
            reg_we_i = (ws == 2'd1) || (ws == 2'd2);
            reg_addr_i = (ws == 2'd1) ? 3'd1 : 3'd6;
            reg_wdata_i = wm;
            @(negedge clk);
            act_i = 0; irq_i = 0; periph_to_i = 0; sw_smi_i = 0; reg_we_i = 0;
            chk_reg("R4 random causes", 3'd1, m_cause);
            chk_reg("R11 random status", 3'd6, m_stat);
            check("R12 random smi_n", {31'd0, smi_n_o}, {31'd0, ~|(m_stat & m_smi_en)});
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule